// File: doc/BRIEF.md
# Frame-Counted Channel Byte FIFO

This block is one byte channel of a telephony line controller. Bytes arrive on a push port and leave on a pop port. Two 9-bit byte pointers track them: a write pointer (Z1) and a read pointer (Z2). Both live in an offset window from 0x080 to 0x1FF rather than starting at zero, and the buffer is addressed relative to the bottom of that window. Beside them, two 4-bit frame counters count complete frames: F1 is advanced when a frame is closed and F2 when the consumer has taken one. Fill levels in bytes and in frames are the pointer differences, corrected modulo the window size.

Software talks to the block through a small command strobe and a read selector. The command strobe carries three self-clearing bits: close a frame, empty the FIFO, and clear the sticky lost flag. The read selector returns the pointers, the frame counters, the lost flag and the byte fill. A level interrupt reports either pending frames (frame mode) or a byte fill at or above a selectable threshold (transparent mode), gated by an enable input.

Top module: `zf_chan_fifo`

## Requirements
- R1: After reset Z1 and Z2 read 0x080, F1 and F2 read 0, the lost flag is 0, and with an empty FIFO irq is 0.
- R2: A push while not full stores push_data at Z1 and advances Z1 by one on that clock edge; Z1 advances from 0x1FF to 0x080.
- R3: A pop while not empty presents the byte at Z2 on pop_data in the same cycle and advances Z2 on the edge, with the same wrap as Z1; bytes leave in push order.
- R4: Byte fill equals Z1 minus Z2, plus 384 when negative, and reads on rd_sel=3 in bits [8:0] with the lost flag in bit 15; at fill 383 the FIFO is full, a push is dropped and the lost flag is set.
- R5: A pop while empty returns the fill byte (0x7E when cfg_iff_ones=0, 0xFF when 1) and leaves Z2 unchanged.
- R6: ctrl_wdata bit 0 written with ctrl_we advances F1 by one on the clock edge after the write cycle; rd_sel=2 returns F1 in bits [7:4] and F2 in bits [3:0], and F1 wraps from 15 to 0.
- R7: When the frame count (F1 minus F2, modulo 16) is 15, a frame-close command is refused, F1 holds and the lost flag is set.
- R8: frame_taken advances F2 by one when the frame count is non-zero and is ignored when it is zero.
- R9: ctrl_wdata bit 1 sets Z1 to Z2 and F1 to F2 on the edge after the write cycle, leaves the lost flag unchanged, and overrides any push, pop, frame close or frame_taken in that cycle.
- R10: ctrl_wdata bit 2 clears the lost flag on the edge after the write cycle; a lost event in that same cycle keeps the flag set.
- R11: In frame mode (cfg_transparent=0) irq is high exactly when irq_en is 1 and the frame count is non-zero.
- R12: In transparent mode irq is high exactly when irq_en is 1, cfg_thresh is non-zero and the byte fill is at least 32 shifted left by cfg_thresh (64 to 4096 bytes).
- R13: Command bits act once per write: a single write cycle causes exactly one action, with no repeat in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Write one byte this cycle |
| push_data | input | 8 | Byte to store |
| pop_req | input | 1 | Remove one byte this cycle |
| pop_data | output | 8 | Byte at Z2, or fill byte when empty |
| frame_taken | input | 1 | Consumer finished one frame (advances F2) |
| ctrl_we | input | 1 | Command strobe |
| ctrl_wdata | input | 3 | Bit 0 close frame, bit 1 empty FIFO, bit 2 clear lost |
| rd_sel | input | 2 | 0 Z1, 1 Z2, 2 F1/F2, 3 lost and fill |
| rd_data | output | 16 | Selected status word |
| cfg_transparent | input | 1 | 0 frame mode, 1 transparent mode |
| cfg_thresh | input | 3 | Transparent interrupt threshold select, 0 = none |
| cfg_iff_ones | input | 1 | Fill byte select, 0 = 0x7E, 1 = 0xFF |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the buffer to exactly 383 bytes and pushes once more; a design that compared against 384 would overwrite the oldest byte and never raise the lost flag. It keeps pushing and popping until both pointers cross 0x1FF, where a pointer that wrapped to zero would read back as a wrong address and corrupt the data order. It closes sixteen frames without consuming any, so that an unguarded F1 would lap F2 and make the FIFO look empty. It also issues empty and clear commands in the same cycle as pushes, pops and lost events, where a wrong priority would leave stale bytes behind or drop a freshly lost event.

// File: rtl/zf_pkg.sv
package zf_pkg;

   // command bit positions on the control strobe
   localparam int unsigned CMD_CLOSE = 0;
   localparam int unsigned CMD_EMPTY = 1;
   localparam int unsigned CMD_UNLOSE = 2;
   localparam int unsigned CMD_W = 3;

   typedef enum logic [1:0] {
      RSEL_WPTR  = 2'd0,
      RSEL_RPTR  = 2'd1,
      RSEL_FCNT  = 2'd2,
      RSEL_STAT  = 2'd3
   } zf_rsel_e;

   function automatic logic [7:0] idle_byte(input logic ones);
      return ones ? 8'hFF : 8'h7E;
   endfunction

endpackage

// File: rtl/zf_store.sv
module zf_store #(
   parameter int unsigned DW   = 8,
   parameter int unsigned ZW   = 9,
   parameter int unsigned ZMIN = 128,
   parameter int unsigned ZMAX = 511
) (
   input  logic          clk,
   input  logic          we,
   input  logic [ZW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [ZW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = ZMAX - ZMIN + 1;
   localparam int unsigned AW    = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] widx, ridx;

   assign widx = AW'(waddr - ZW'(ZMIN));
   assign ridx = AW'(raddr - ZW'(ZMIN));

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/zf_ptrs.sv
module zf_ptrs
   import zf_pkg::*;
#(
   parameter int unsigned ZW   = 9,
   parameter int unsigned FW   = 4,
   parameter int unsigned ZMIN = 128,
   parameter int unsigned ZMAX = 511
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic              pop_req,
   input  logic              frame_taken,
   input  logic              ctrl_we,
   input  logic [CMD_W-1:0]  ctrl_wdata,
   output logic [ZW-1:0]     z1,
   output logic [ZW-1:0]     z2,
   output logic [FW-1:0]     f1,
   output logic [FW-1:0]     f2,
   output logic              lost,
   output logic [ZW-1:0]     fill,
   output logic [FW-1:0]     frames,
   output logic              push_ok,
   output logic              empty,
   output logic [CMD_W-1:0]  cmd_q
);
   localparam int unsigned DEPTH = ZMAX - ZMIN + 1;
   localparam logic [ZW-1:0] ZLO  = ZW'(ZMIN);
   localparam logic [ZW-1:0] ZHI  = ZW'(ZMAX);
   localparam logic [ZW-1:0] FULL = ZW'(DEPTH - 1);
   localparam logic [FW-1:0] FTOP = '1;

   logic [ZW:0] zdiff;
   logic        full, do_empty, do_close, close_ok, pop_ok, take_ok, lose_now;

   function automatic logic [ZW-1:0] zstep(input logic [ZW-1:0] z);
      return (z == ZHI) ? ZLO : z + 1'b1;
   endfunction

   // byte fill modulo the window size
   assign zdiff = {1'b0, z1} - {1'b0, z2};
   always_comb begin
      if (z1 >= z2) fill = zdiff[ZW-1:0];
      else          fill = ZW'(zdiff + (ZW+1)'(DEPTH));
   end

   assign frames   = f1 - f2;
   assign full     = (fill == FULL);
   assign empty    = (fill == '0);

   assign do_empty = cmd_q[CMD_EMPTY];
   assign do_close = cmd_q[CMD_CLOSE] & ~do_empty;
   assign close_ok = do_close & (frames != FTOP);
   assign push_ok  = push_valid & ~full & ~do_empty;
   assign pop_ok   = pop_req & ~empty & ~do_empty;
   assign take_ok  = frame_taken & (frames != '0) & ~do_empty;
   assign lose_now = (push_valid & full & ~do_empty) | (do_close & (frames == FTOP));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         z1    <= ZLO;
         z2    <= ZLO;
         f1    <= '0;
         f2    <= '0;
         lost  <= 1'b0;
      end else begin
         cmd_q <= ctrl_we ? ctrl_wdata : '0;
         if (do_empty) begin
            z1 <= z2;
            f1 <= f2;
         end else begin
            if (push_ok)  z1 <= zstep(z1);
            if (pop_ok)   z2 <= zstep(z2);
            if (close_ok) f1 <= f1 + 1'b1;
            if (take_ok)  f2 <= f2 + 1'b1;
         end
         if (lose_now)                lost <= 1'b1;
         else if (cmd_q[CMD_UNLOSE])  lost <= 1'b0;
      end
   end
endmodule

// File: rtl/zf_irq.sv
module zf_irq #(
   parameter int unsigned ZW = 9,
   parameter int unsigned FW = 4
) (
   input  logic          transparent,
   input  logic [2:0]    thresh,
   input  logic          enable,
   input  logic [ZW-1:0] fill,
   input  logic [FW-1:0] frames,
   output logic          irq
);
   logic [7:0] at_level;

   assign at_level[0] = 1'b0;
   for (genvar k = 1; k < 8; k++) begin : g_lvl
      localparam logic [31:0] LVL = 32'd32 << k;
      assign at_level[k] = (32'(fill) >= LVL);
   end

   logic cond;
   assign cond = transparent ? at_level[thresh] : (frames != '0);
   assign irq  = enable & cond;
endmodule

// File: rtl/zf_chan_fifo.sv
module zf_chan_fifo
   import zf_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned ZW   = 9,
   parameter int unsigned FW   = 4,
   parameter int unsigned ZMIN = 128,
   parameter int unsigned ZMAX = 511,
   parameter int unsigned RDW  = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_valid,
   input  logic [DW-1:0]  push_data,
   input  logic           pop_req,
   output logic [DW-1:0]  pop_data,
   input  logic           frame_taken,
   input  logic           ctrl_we,
   input  logic [2:0]     ctrl_wdata,
   input  logic [1:0]     rd_sel,
   output logic [RDW-1:0] rd_data,
   input  logic           cfg_transparent,
   input  logic [2:0]     cfg_thresh,
   input  logic           cfg_iff_ones,
   input  logic           irq_en,
   output logic           irq
);
   if (ZMAX <= ZMIN)          begin : g_bad_win  $error("pointer window empty");      end
   if (ZMAX >= (1 << ZW))     begin : g_bad_zw   $error("ZW too narrow for window");  end
   if (RDW < ZW + 1)          begin : g_bad_rdw  $error("RDW too narrow");            end
   if (RDW < 2 * FW)          begin : g_bad_rdf  $error("RDW too narrow for F pair"); end
   if (DW != 8)               begin : g_bad_dw   $error("fill byte needs DW=8");      end

   logic [ZW-1:0]    z1_w, z2_w, fill_w;
   logic [FW-1:0]    f1_w, f2_w, frames_w;
   logic             lost_w, push_ok_w, empty_w;
   logic [CMD_W-1:0] cmd_w;
   logic [DW-1:0]    mem_rd;

   zf_ptrs #(.ZW(ZW), .FW(FW), .ZMIN(ZMIN), .ZMAX(ZMAX)) u_ptrs (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .pop_req(pop_req), .frame_taken(frame_taken),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .z1(z1_w), .z2(z2_w), .f1(f1_w), .f2(f2_w), .lost(lost_w),
      .fill(fill_w), .frames(frames_w), .push_ok(push_ok_w), .empty(empty_w),
      .cmd_q(cmd_w)
   );

   zf_store #(.DW(DW), .ZW(ZW), .ZMIN(ZMIN), .ZMAX(ZMAX)) u_store (
      .clk(clk), .we(push_ok_w), .waddr(z1_w), .wdata(push_data),
      .raddr(z2_w), .rdata(mem_rd)
   );

   zf_irq #(.ZW(ZW), .FW(FW)) u_irq (
      .transparent(cfg_transparent), .thresh(cfg_thresh), .enable(irq_en),
      .fill(fill_w), .frames(frames_w), .irq(irq)
   );

   assign pop_data = empty_w ? idle_byte(cfg_iff_ones) : mem_rd;

   always_comb begin
      rd_data = '0;
      case (zf_rsel_e'(rd_sel))
         RSEL_WPTR: rd_data = RDW'(z1_w);
         RSEL_RPTR: rd_data = RDW'(z2_w);
         RSEL_FCNT: rd_data = RDW'({f1_w, f2_w});
         default: begin
            rd_data[ZW-1:0] = fill_w;
            rd_data[RDW-1]  = lost_w;
         end
      endcase
   end
endmodule

// File: rtl/zf_chan_fifo_chk.sv
module zf_chan_fifo_chk #(
   parameter int unsigned DW   = 8,
   parameter int unsigned ZW   = 9,
   parameter int unsigned FW   = 4,
   parameter int unsigned ZMIN = 128,
   parameter int unsigned ZMAX = 511
) (
   input logic          clk,
   input logic          rst_n,
   input logic          push_valid,
   input logic          pop_req,
   input logic [DW-1:0] pop_data,
   input logic          cfg_iff_ones,
   input logic          cfg_transparent,
   input logic          irq_en,
   input logic          irq,
   input logic [ZW-1:0] z1,
   input logic [ZW-1:0] z2,
   input logic [FW-1:0] f1,
   input logic [FW-1:0] f2,
   input logic          lost,
   input logic [ZW-1:0] fill,
   input logic [2:0]    cmd
);
   localparam logic [ZW-1:0] FULL = ZW'(ZMAX - ZMIN);

   p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (z1 >= ZW'(ZMIN)) && (z1 <= ZW'(ZMAX)) && (z2 >= ZW'(ZMIN)) && (z2 <= ZW'(ZMAX)));

   p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == FULL && push_valid && !cmd[1]) |=> (lost && $stable(z1)));

   p_idle_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0 && pop_req) |-> (pop_data == (cfg_iff_ones ? 8'hFF : 8'h7E)));

   p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == '0 && pop_req) |=> $stable(z2));

   p_close_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd[0] && !cmd[1] && FW'(f1 - f2) == '1) |=> (lost && $stable(f1)));

   p_empty_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[1] |=> (z1 == $past(z2) && f1 == $past(f2)));

   p_lost_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lost) |-> $past(cmd[2]));

   p_irq_frames_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_transparent |-> (irq == (irq_en && (f1 != f2))));
endmodule

bind zf_chan_fifo zf_chan_fifo_chk #(
   .DW(DW), .ZW(ZW), .FW(FW), .ZMIN(ZMIN), .ZMAX(ZMAX)
) i_chk (
   .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
   .pop_data(pop_data), .cfg_iff_ones(cfg_iff_ones),
   .cfg_transparent(cfg_transparent), .irq_en(irq_en), .irq(irq),
   .z1(z1_w), .z2(z2_w), .f1(f1_w), .f2(f2_w), .lost(lost_w),
   .fill(fill_w), .cmd(cmd_w)
);

// File: tb/test_zf_chan_fifo.sv
`timescale 1ns/1ps
module test_zf_chan_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int ZLO = 128;
   localparam int ZHI = 511;
   localparam int SPAN = ZHI - ZLO + 1;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        push_valid, pop_req, frame_taken, ctrl_we;
   logic [7:0]  push_data, pop_data;
   logic [2:0]  ctrl_wdata, cfg_thresh;
   logic [1:0]  rd_sel;
   logic [15:0] rd_data;
   logic        cfg_transparent, cfg_iff_ones, irq_en, irq;

   zf_chan_fifo i_zf_chan_fifo (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .pop_req(pop_req), .pop_data(pop_data), .frame_taken(frame_taken),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
      .cfg_transparent(cfg_transparent), .cfg_thresh(cfg_thresh),
      .cfg_iff_ones(cfg_iff_ones), .irq_en(irq_en), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int       m_z1, m_z2, m_f1, m_f2;
   bit       m_lost;
   bit [2:0] m_cmd;
   bit [7:0] m_mem [SPAN];

   function automatic int zn(input int z);
      return (z == ZHI) ? ZLO : z + 1;
   endfunction
   function automatic int m_fill();
      int d = m_z1 - m_z2;
      return (d < 0) ? d + SPAN : d;
   endfunction
   function automatic int m_frames();
      int d = m_f1 - m_f2;
      return (d < 0) ? d + 16 : d;
   endfunction
   function automatic bit m_irq();
      if (!irq_en) return 1'b0;
      if (!cfg_transparent) return m_frames() != 0;
      if (cfg_thresh == 3'd0) return 1'b0;
      return m_fill() >= (32 << cfg_thresh);
   endfunction
   function automatic int m_pop();
      if (m_fill() == 0) return cfg_iff_ones ? 8'hFF : 8'h7E;
      return m_mem[m_z2 - ZLO];
   endfunction

   task automatic chk(input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic model_edge(input bit pu, input bit [7:0] pd, input bit po,
                             input bit tk, input bit we, input bit [2:0] wd);
      int  fl = m_fill();
      int  fr = m_frames();
      bit  clr = m_cmd[1];
      bit  setl = !clr && ((pu && fl == SPAN-1) || (m_cmd[0] && fr == 15));
      if (clr) begin
         m_z1 = m_z2;
         m_f1 = m_f2;
      end else begin
         if (pu && fl != SPAN-1) begin m_mem[m_z1 - ZLO] = pd; m_z1 = zn(m_z1); end
         if (po && fl != 0) m_z2 = zn(m_z2);
         if (m_cmd[0] && fr != 15) m_f1 = (m_f1 + 1) % 16;
         if (tk && fr != 0) m_f2 = (m_f2 + 1) % 16;
      end
      if (setl) m_lost = 1'b1;
      else if (m_cmd[2]) m_lost = 1'b0;
      m_cmd = we ? wd : 3'b000;
   endtask

   task automatic step(input bit pu, input bit [7:0] pd, input bit po, input bit tk,
                       input bit we, input bit [2:0] wd, input string tag);
      @(negedge clk);
      push_valid = pu; push_data = pd; pop_req = po; frame_taken = tk;
      ctrl_we = we; ctrl_wdata = wd;
      rd_sel = 2'd0; #0.5; chk(rd_data, m_z1, {tag, " Z1"});
      rd_sel = 2'd1; #0.5; chk(rd_data, m_z2, {tag, " Z2"});
      rd_sel = 2'd2; #0.5; chk(rd_data, (m_f1 << 4) | m_f2, {tag, " F1/F2"});
      rd_sel = 2'd3; #0.5; chk(rd_data, (int'(m_lost) << 15) | m_fill(), {tag, " lost/fill"});
      chk(pop_data, m_pop(), {tag, " pop_data"});
      chk(irq, m_irq(), {tag, " irq"});
      @(posedge clk);
      model_edge(pu, pd, po, tk, we, wd);
   endtask

   task automatic idle(input string tag);
      step(0, 8'h00, 0, 0, 0, 3'b000, tag);
   endtask

   // watchdog
   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; push_valid = 0; push_data = 0; pop_req = 0; frame_taken = 0;
      ctrl_we = 0; ctrl_wdata = 0; rd_sel = 0;
      cfg_transparent = 0; cfg_thresh = 0; cfg_iff_ones = 0; irq_en = 1;
      m_z1 = ZLO; m_z2 = ZLO; m_f1 = 0; m_f2 = 0; m_lost = 0; m_cmd = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      idle("R1 reset state");

      // R2/R3: ordered push and pop
      for (int i = 0; i < 5; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 3'b000, "R2 push");
      for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 0, 0, 3'b000, "R3 pop order");

      // R5: pop when empty, both fill bytes
      step(0, 8'h00, 1, 0, 0, 3'b000, "R5 empty pop 7E");
      cfg_iff_ones = 1;
      step(0, 8'h00, 1, 0, 0, 3'b000, "R5 empty pop FF");
      cfg_iff_ones = 0;

      // R4: fill to full, overflow drops and sets lost; pointers cross the top
      for (int i = 0; i < SPAN + 2; i++)
         step(1, 8'(i * 7 + 3), 0, 0, 0, 3'b000, "R4 fill to full");
      idle("R4 lost after overflow");
      // R10: clear lost, then clear colliding with a new overflow
      step(0, 8'h00, 0, 0, 1, 3'b100, "R10 clear lost write");
      idle("R10 lost cleared");
      step(0, 8'h00, 0, 0, 1, 3'b100, "R10 clear write again");
      step(1, 8'h55, 0, 0, 0, 3'b000, "R10 overflow beats clear");
      idle("R10 lost kept");
      // R2/R3 wrap: drain the full buffer across 0x1FF
      for (int i = 0; i < SPAN; i++) step(0, 8'h00, 1, 0, 0, 3'b000, "R3 drain across wrap");
      step(0, 8'h00, 0, 0, 1, 3'b100, "R10 clear");
      idle("R10 settle");

      // R6/R7/R13: close sixteen frames without taking any
      for (int i = 0; i < 16; i++) begin
         step(0, 8'h00, 0, 0, 1, 3'b001, "R6 close frame");
         idle("R13 single action per write");
      end
      idle("R7 sixteenth close refused");
      // R11: frame mode interrupt with frames pending, then disabled
      irq_en = 0; idle("R11 irq gated off");
      irq_en = 1; idle("R11 irq frames pending");
      // R8: take all frames, then extra takes are ignored
      for (int i = 0; i < 17; i++) step(0, 8'h00, 0, 1, 0, 3'b000, "R8 frame taken");
      idle("R11 irq no frames");
      // R6 wrap of F1 past 15
      for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 0, 1, 3'b001, "R6 F1 wrap");
      idle("R6 settle");

      // R9: empty command with data present, colliding with push and pop
      for (int i = 0; i < 10; i++) step(1, 8'h30 + 8'(i), 0, 0, 0, 3'b000, "R9 preload");
      step(0, 8'h00, 0, 0, 1, 3'b011, "R9 empty and close write");
      step(1, 8'hEE, 1, 1, 0, 3'b000, "R9 empty overrides");
      idle("R9 after empty");

      // R12: transparent threshold at 64 bytes
      cfg_transparent = 1; cfg_thresh = 3'd1;
      for (int i = 0; i < 66; i++) step(1, 8'(i), 0, 0, 0, 3'b000, "R12 fill to 64");
      cfg_thresh = 3'd2; idle("R12 threshold 128 not met");
      cfg_thresh = 3'd0; idle("R12 threshold none");
      cfg_thresh = 3'd1;
      for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 0, 0, 3'b000, "R12 drop below 64");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         bit [31:0] r = $urandom;
         bit [2:0]  wd;
         bit        we;
         if (i % 500 == 0) begin
            cfg_transparent = r[20]; cfg_thresh = 3'(r[23:21] % 4); cfg_iff_ones = r[24];
         end
         we = (r[7:4] == 4'd0);
         wd = {r[8], (r[15:10] == 6'd0), r[9]};
         step(r[0] | r[1], 8'(r >> 24), r[2] & (r[3] | r[16]), (r[19:17] == 3'd0),
              we, wd, "R2 R3 R4 R8 random");
      end
      idle("random final");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule